// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Nesting Tracker

This block keeps the interrupt nesting state of a single processor. When the processor acknowledges, the block compares the highest pending interrupt, which an arbiter elsewhere supplies, against the priority of the interrupt that is running now. If the pending one wins, it preempts the running one and the block asks for its pending state to be cleared. Each preempted interrupt is kept as the predecessor of the interrupt that displaced it. A table indexed by interrupt ID holds these predecessors and forms a singly linked chain that ends at the spurious ID 1023.

End-of-interrupt writes normally complete the running interrupt, and its predecessor then resumes. Software may also complete an interrupt deeper in the chain. In that case a small state machine follows the chain one link per cycle and splices the completed ID out of it. While the walk is in progress, both request channels are back-pressured.

Acknowledge and end-of-interrupt requests use valid/ready. A request is taken on a rising edge where both valid and ready are high. If both requests are valid in the same cycle, the acknowledge is taken and the end-of-interrupt waits. The acknowledge response, the clear-pending request and the re-pend request are single-cycle pulses and cannot be back-pressured. The user must not present an ID that is already in the chain as pending.

Top module: `nest_tracker`

## Requirements
- R1: After reset, run_id is 1023 and run_prio is 0x100. ack_rsp_valid, clr_valid and set_pend_valid are low, and both ready outputs are high.
- R2: An acknowledge with pend_id equal to 1023, or at or above NUM_IRQ, returns ack_rsp_id 1023 and raises no clr_valid. run_id is unchanged.
- R3: An acknowledge whose pend_prio is not strictly below run_prio, the equal case included, returns 1023 and changes no state.
- R4: A successful acknowledge returns pend_id on ack_rsp_id and pulses clr_valid with clr_id equal to pend_id, both one cycle after acceptance. run_id then equals pend_id, and the previous run_id is stored as its predecessor.
- R5: prio_q_id always shows run_id. run_prio is 0x100 when run_id is 1023 and {0, prio_q_val} otherwise.
- R6: The end-of-interrupt ID is eoi_data[9:0], and the upper bits have no effect.
- R7: An end-of-interrupt with an ID at or above NUM_IRQ, 1023 included, is ignored. run_id stays the same and no re-pend pulse is raised.
- R8: An end-of-interrupt accepted while run_id is 1023 is ignored, and no re-pend pulse is raised.
- R9: Completing the running ID makes its stored predecessor the new run_id, one cycle after acceptance.
- R10: Completing an ID deeper in the chain leaves run_id unchanged and removes that ID from the chain. A later completion of its successor then resumes the removed ID's predecessor.
- R11: If a completed ID is not in the chain, the walk ends with no change.
- R12: lvl_q_id always shows eoi_data[9:0]. When legacy_mode and lvl_q_hit are both high on an end-of-interrupt that is not ignored, set_pend_valid pulses one cycle later with set_pend_id equal to that ID.
- R13: Both ready outputs are low from the cycle after a deep completion is accepted until the walk ends. eoi_ready is also low whenever ack_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_valid | input | 1 | Acknowledge request |
| ack_ready | output | 1 | Acknowledge can be taken |
| pend_id | input | 10 | Highest pending interrupt ID |
| pend_prio | input | PRIO_W | Priority of pend_id |
| ack_rsp_valid | output | 1 | Acknowledge response pulse |
| ack_rsp_id | output | 10 | Acknowledged ID or 1023 |
| clr_valid | output | 1 | Clear-pending request pulse |
| clr_id | output | 10 | ID whose pending state is cleared |
| eoi_valid | input | 1 | End-of-interrupt request |
| eoi_ready | output | 1 | End-of-interrupt can be taken |
| eoi_data | input | 32 | Written completion value, ID in bits 9:0 |
| legacy_mode | input | 1 | Enables level re-pend on completion |
| lvl_q_id | output | 10 | ID queried for level re-pend |
| lvl_q_hit | input | 1 | Queried ID is level, enabled, asserted and targeted here |
| set_pend_valid | output | 1 | Re-pend request pulse |
| set_pend_id | output | 10 | ID to mark pending again |
| prio_q_id | output | 10 | ID whose priority is looked up |
| prio_q_val | input | PRIO_W | Priority of prio_q_id |
| run_id | output | 10 | Running interrupt ID |
| run_prio | output | PRIO_W+1 | Running priority, 0x100 when idle |

## Verification
The acknowledge response, the clear pulse and the re-pend pulse all appear one cycle after the accepting edge. The bench drives each request on a falling edge and samples these outputs on the next falling edge. run_id and run_prio reach their new values on the same edge for an acknowledge and for completion of the running interrupt. After a deep completion, the readies are low from the next cycle. The bench checks that, then waits for both readies before it compares run_id and run_prio with its model. Later completions expose the chain contents through run_id.

// File: rtl/nt_pkg.sv
package nt_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPUR_ID = 10'h3FF;
  typedef logic [ID_W-1:0] irq_id_t;
  typedef enum logic {W_IDLE, W_STEP} walk_st_t;
endpackage

// File: rtl/nt_link_mem.sv
module nt_link_mem
  import nt_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  irq_id_t          wval,
  input  logic [IDX_W-1:0] ra_idx,
  output irq_id_t          ra_val,
  input  logic [IDX_W-1:0] rb_idx,
  output irq_id_t          rb_val
);
  localparam int DEPTH = 1 << IDX_W;

  irq_id_t links [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) links[i] <= SPUR_ID;
    end else if (we) begin
      links[widx] <= wval;
    end
  end

  assign ra_val = links[ra_idx];
  assign rb_val = links[rb_idx];
endmodule

// File: rtl/nt_chain_walker.sv
module nt_chain_walker
  import nt_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] start_cur,
  input  irq_id_t          start_tgt,
  input  irq_id_t          link_cur,
  input  irq_id_t          link_tgt,
  output logic             busy,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] tgt_idx,
  output logic             fix_we,
  output logic [IDX_W-1:0] fix_idx,
  output irq_id_t          fix_val
);
  walk_st_t         st;
  logic [IDX_W-1:0] cur;
  irq_id_t          tgt;
  logic             at_end;
  logic             hit;

  assign at_end = (link_cur == SPUR_ID);
  assign hit    = !at_end && (link_cur == tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= W_IDLE;
      cur <= '0;
      tgt <= SPUR_ID;
    end else begin
      case (st)
        W_IDLE: begin
          if (start) begin
            st  <= W_STEP;
            cur <= start_cur;
            tgt <= start_tgt;
          end
        end
        W_STEP: begin
          if (at_end || hit) st <= W_IDLE;
          else cur <= link_cur[IDX_W-1:0];
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign busy    = (st == W_STEP);
  assign cur_idx = cur;
  assign tgt_idx = tgt[IDX_W-1:0];
  assign fix_we  = busy && hit;
  assign fix_idx = cur;
  assign fix_val = link_tgt;
endmodule

// File: rtl/nest_tracker.sv
module nest_tracker
  import nt_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_valid,
  output logic              ack_ready,
  input  logic [9:0]        pend_id,
  input  logic [PRIO_W-1:0] pend_prio,
  output logic              ack_rsp_valid,
  output logic [9:0]        ack_rsp_id,
  output logic              clr_valid,
  output logic [9:0]        clr_id,
  input  logic              eoi_valid,
  output logic              eoi_ready,
  input  logic [31:0]       eoi_data,
  input  logic              legacy_mode,
  output logic [9:0]        lvl_q_id,
  input  logic              lvl_q_hit,
  output logic              set_pend_valid,
  output logic [9:0]        set_pend_id,
  output logic [9:0]        prio_q_id,
  input  logic [PRIO_W-1:0] prio_q_val,
  output logic [9:0]        run_id,
  output logic [PRIO_W:0]   run_prio
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam irq_id_t ID_LIMIT = irq_id_t'(NUM_IRQ);
  localparam logic [PRIO_W:0] IDLE_PRIO = (PRIO_W + 1)'(1) << PRIO_W;

  irq_id_t run_q;
  irq_id_t eid;
  logic    unused_hi;
  logic    walk_busy;
  logic    ack_fire, ack_win;
  logic    eoi_fire, eoi_live, eoi_top, eoi_deep;

  logic [IDX_W-1:0] walk_cur, walk_tgt, fix_idx;
  logic             fix_we;
  irq_id_t          fix_val;
  irq_id_t          ra_val, rb_val;
  logic [IDX_W-1:0] ra_idx, mem_widx;
  logic             mem_we;
  irq_id_t          mem_wval;

  assign eid       = eoi_data[ID_W-1:0];
  assign unused_hi = ^eoi_data[31:ID_W];

  assign run_prio  = (run_q == SPUR_ID) ? IDLE_PRIO : {1'b0, prio_q_val};
  assign prio_q_id = run_q;
  assign run_id    = run_q;
  assign lvl_q_id  = eid;

  assign ack_ready = !walk_busy;
  assign eoi_ready = !walk_busy && !ack_valid;

  assign ack_fire = ack_valid && ack_ready;
  assign ack_win  = ack_fire && (pend_id < ID_LIMIT) && ({1'b0, pend_prio} < run_prio);

  assign eoi_fire = eoi_valid && eoi_ready;
  assign eoi_live = eoi_fire && (eid < ID_LIMIT) && (run_q != SPUR_ID);
  assign eoi_top  = eoi_live && (eid == run_q);
  assign eoi_deep = eoi_live && (eid != run_q);

  assign ra_idx   = walk_busy ? walk_cur : run_q[IDX_W-1:0];
  assign mem_we   = ack_win || fix_we;
  assign mem_widx = ack_win ? pend_id[IDX_W-1:0] : fix_idx;
  assign mem_wval = ack_win ? run_q : fix_val;

  nt_link_mem #(.IDX_W(IDX_W)) u_links (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (mem_we),
    .widx   (mem_widx),
    .wval   (mem_wval),
    .ra_idx (ra_idx),
    .ra_val (ra_val),
    .rb_idx (walk_tgt),
    .rb_val (rb_val)
  );

  nt_chain_walker #(.IDX_W(IDX_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (eoi_deep),
    .start_cur (run_q[IDX_W-1:0]),
    .start_tgt (eid),
    .link_cur  (ra_val),
    .link_tgt  (rb_val),
    .busy      (walk_busy),
    .cur_idx   (walk_cur),
    .tgt_idx   (walk_tgt),
    .fix_we    (fix_we),
    .fix_idx   (fix_idx),
    .fix_val   (fix_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q          <= SPUR_ID;
      ack_rsp_valid  <= 1'b0;
      ack_rsp_id     <= SPUR_ID;
      clr_valid      <= 1'b0;
      clr_id         <= SPUR_ID;
      set_pend_valid <= 1'b0;
      set_pend_id    <= SPUR_ID;
    end else begin
      ack_rsp_valid  <= ack_fire;
      clr_valid      <= ack_win;
      set_pend_valid <= eoi_live && legacy_mode && lvl_q_hit;
      if (ack_fire) ack_rsp_id <= ack_win ? pend_id : SPUR_ID;
      if (ack_win) begin
        clr_id <= pend_id;
        run_q  <= pend_id;
      end else if (eoi_top) begin
        run_q <= ra_val;
      end
      if (eoi_live) set_pend_id <= eid;
    end
  end
endmodule

// File: rtl/nt_checker.sv
module nt_checker
  import nt_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_valid,
  input logic              ack_ready,
  input logic [9:0]        pend_id,
  input logic [PRIO_W-1:0] pend_prio,
  input logic              ack_rsp_valid,
  input logic [9:0]        ack_rsp_id,
  input logic              clr_valid,
  input logic [9:0]        clr_id,
  input logic              eoi_valid,
  input logic              eoi_ready,
  input logic [31:0]       eoi_data,
  input logic              set_pend_valid,
  input logic [9:0]        run_id,
  input logic [PRIO_W:0]   run_prio
);
  localparam irq_id_t LIM = irq_id_t'(NUM_IRQ);

  // R2
  ack_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready && pend_id == SPUR_ID)
      |=> (ack_rsp_valid && ack_rsp_id == SPUR_ID && !clr_valid && $stable(run_id)));

  // R3
  ack_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready && pend_id < LIM && {1'b0, pend_prio} >= run_prio)
      |=> (ack_rsp_id == SPUR_ID && !clr_valid && $stable(run_id)));

  // R4
  ack_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> (ack_rsp_valid && ack_rsp_id == clr_id && run_id == clr_id));

  // R7
  eoi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_ready && eoi_data[9:0] >= LIM)
      |=> ($stable(run_id) && !set_pend_valid));

  // R8
  eoi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_ready && run_id == SPUR_ID)
      |=> (run_id == SPUR_ID && !set_pend_valid));

  // R13
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_ready |=> $stable(run_id));
endmodule

bind nest_tracker nt_checker #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ack_valid      (ack_valid),
  .ack_ready      (ack_ready),
  .pend_id        (pend_id),
  .pend_prio      (pend_prio),
  .ack_rsp_valid  (ack_rsp_valid),
  .ack_rsp_id     (ack_rsp_id),
  .clr_valid      (clr_valid),
  .clr_id         (clr_id),
  .eoi_valid      (eoi_valid),
  .eoi_ready      (eoi_ready),
  .eoi_data       (eoi_data),
  .set_pend_valid (set_pend_valid),
  .run_id         (run_id),
  .run_prio       (run_prio)
);

// File: tb/sim_nest_tracker.sv
`timescale 1ns/1ps
module sim_nest_tracker;
  localparam int NIRQ = 64;
  localparam int SP = 1023;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ack_valid = 1'b0;
  logic        ack_ready;
  logic [9:0]  pend_id = 10'h3FF;
  logic [7:0]  pend_prio = 8'h00;
  logic        ack_rsp_valid;
  logic [9:0]  ack_rsp_id;
  logic        clr_valid;
  logic [9:0]  clr_id;
  logic        eoi_valid = 1'b0;
  logic        eoi_ready;
  logic [31:0] eoi_data = 32'h0;
  logic        legacy_mode = 1'b0;
  logic [9:0]  lvl_q_id;
  logic        lvl_q_hit;
  logic        set_pend_valid;
  logic [9:0]  set_pend_id;
  logic [9:0]  prio_q_id;
  logic [7:0]  prio_q_val;
  logic [9:0]  run_id;
  logic [8:0]  run_prio;

  logic [7:0] prio_tab [0:1023];
  logic       lvl_tab  [0:1023];
  int m_run;
  int m_link [0:NIRQ-1];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign prio_q_val = prio_tab[prio_q_id];
  assign lvl_q_hit  = lvl_tab[lvl_q_id];

  nest_tracker #(.NUM_IRQ(NIRQ), .PRIO_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_ready(ack_ready),
    .pend_id(pend_id), .pend_prio(pend_prio), .ack_rsp_valid(ack_rsp_valid),
    .ack_rsp_id(ack_rsp_id), .clr_valid(clr_valid), .clr_id(clr_id),
    .eoi_valid(eoi_valid), .eoi_ready(eoi_ready), .eoi_data(eoi_data),
    .legacy_mode(legacy_mode), .lvl_q_id(lvl_q_id), .lvl_q_hit(lvl_q_hit),
    .set_pend_valid(set_pend_valid), .set_pend_id(set_pend_id),
    .prio_q_id(prio_q_id), .prio_q_val(prio_q_val), .run_id(run_id),
    .run_prio(run_prio));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic int exp_prio();
    return (m_run == SP) ? 256 : int'(prio_tab[m_run]);
  endfunction

  function automatic bit in_chain(input int id);
    int cur = m_run;
    for (int k = 0; k < NIRQ + 2; k++) begin
      if (cur == SP) return 0;
      if (cur == id) return 1;
      cur = m_link[cur];
    end
    return 0;
  endfunction

  task automatic model_unlink(input int t);
    int cur = m_run;
    for (int k = 0; k < NIRQ + 2; k++) begin
      if (m_link[cur] == SP) return;
      if (m_link[cur] == t) begin
        m_link[cur] = m_link[t];
        return;
      end
      cur = m_link[cur];
    end
  endtask

  task automatic wait_idle();
    while (!(ack_ready && eoi_ready)) @(negedge clk);
  endtask

  task automatic check_run(input string req);
    check({req, " run_id"}, int'(run_id), m_run);
    check({req, " run_prio"}, int'(run_prio), exp_prio());
  endtask

  task automatic do_ack(input int id, input logic [7:0] pr, input string req);
    bit ok;
    @(negedge clk);
    wait_idle();
    ok = (id < NIRQ) && (int'(pr) < exp_prio());
    pend_id = 10'(id);
    pend_prio = pr;
    ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
    check({req, " rsp_valid"}, int'(ack_rsp_valid), 1);
    check({req, " rsp_id"}, int'(ack_rsp_id), ok ? id : SP);
    check({req, " clr_valid"}, int'(clr_valid), int'(ok));
    if (ok) begin
      check({req, " clr_id"}, int'(clr_id), id);
      m_link[id] = m_run;
      m_run = id;
    end
    check_run(req);
  endtask

  task automatic do_eoi(input logic [31:0] data, input string req);
    int eid;
    bit live, deep, sp;
    @(negedge clk);
    wait_idle();
    eid = int'(data[9:0]);
    live = (eid < NIRQ) && (m_run != SP);
    deep = live && (eid != m_run);
    sp = live && legacy_mode && lvl_tab[eid];
    eoi_data = data;
    eoi_valid = 1'b1;
    @(negedge clk);
    eoi_valid = 1'b0;
    check({req, " set_pend_valid"}, int'(set_pend_valid), int'(sp));
    if (sp) check({req, " set_pend_id"}, int'(set_pend_id), eid);
    if (deep) check({req, " R13 ack_ready low during walk"}, int'(ack_ready), 0);
    if (live) begin
      if (eid == m_run) m_run = m_link[m_run];
      else model_unlink(eid);
    end
    wait_idle();
    check_run(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog", 1, 0);
    finish_up();
  end

  initial begin
    int seed;
    int id, dep, cur;
    seed = $urandom(32'd4711);
    for (int i = 0; i < 1024; i++) begin
      prio_tab[i] = 8'($urandom);
      lvl_tab[i] = 1'b0;
    end
    for (int i = 0; i < NIRQ; i++) m_link[i] = SP;
    m_run = SP;
    prio_tab[5] = 8'd40; prio_tab[9] = 8'd20;
    prio_tab[12] = 8'd10; prio_tab[3] = 8'd10; prio_tab[30] = 8'd90;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 run_id", int'(run_id), SP);
    check("R1 run_prio", int'(run_prio), 256);
    check("R1 rsp_valid", int'(ack_rsp_valid), 0);
    check("R1 clr_valid", int'(clr_valid), 0);
    check("R1 set_pend_valid", int'(set_pend_valid), 0);
    check("R1 readies", int'({ack_ready, eoi_ready}), 3);

    do_ack(SP, 8'd0, "R2 spurious pend");
    do_ack(100, 8'd0, "R2 out of range pend");
    do_ack(5, 8'd40, "R4 first ack");
    check("R5 prio_q_id", int'(prio_q_id), 5);
    do_ack(9, 8'd20, "R4 nested ack");
    do_ack(12, 8'd10, "R4 deeper ack");
    do_ack(3, 8'd10, "R3 equal priority");
    do_eoi(32'd9, "R10 out of order");
    do_eoi({22'h2AB3C, 10'd12}, "R6 R9 R10 complete top skips removed");
    do_eoi(32'd30, "R11 not in chain");
    do_eoi(32'd1023, "R7 spurious eoi");
    do_eoi(32'd64, "R7 out of range eoi");
    lvl_tab[5] = 1'b1;
    legacy_mode = 1'b0;
    do_ack(9, 8'd20, "R4 reacquire");
    do_eoi(32'd9, "R9 complete running");
    legacy_mode = 1'b1;
    do_eoi(32'd5, "R12 legacy re-pend");
    do_eoi(32'd5, "R8 eoi while idle");
    do_ack(9, 8'd20, "R4 setup for R13");
    // R13 ack wins over concurrent eoi
    @(negedge clk);
    wait_idle();
    pend_id = 10'h3FF;
    ack_valid = 1'b1;
    eoi_data = 32'd9;
    eoi_valid = 1'b1;
    #1;
    check("R13 eoi_ready low with ack_valid", int'(eoi_ready), 0);
    @(negedge clk);
    ack_valid = 1'b0;
    eoi_valid = 1'b0;
    check("R13 ack taken", int'(ack_rsp_id), SP);
    check_run("R13 eoi held off");
    do_eoi(32'd9, "R9 final completion");

    for (int n = 0; n < 400; n++) begin
      legacy_mode = 1'($urandom);
      lvl_tab[$urandom % NIRQ] = 1'($urandom);
      if ($urandom % 2 == 0) begin
        id = ($urandom % 8 == 0) ? SP : int'($urandom % NIRQ);
        if (id != SP && in_chain(id)) id = SP;
        do_ack(id, (id < NIRQ) ? prio_tab[id] : 8'($urandom), "R4 random ack");
      end else begin
        if (m_run != SP && $urandom % 4 != 0) begin
          dep = int'($urandom % 4);
          cur = m_run;
          for (int k = 0; k < dep; k++) if (m_link[cur] != SP) cur = m_link[cur];
          id = cur;
        end else begin
          id = ($urandom % 6 == 0) ? SP : int'($urandom % 80);
        end
        do_eoi({22'($urandom), 10'(id)}, "R10 random eoi");
      end
    end
    finish_up();
  end
endmodule